// File: doc/BRIEF.md
# Test Access Port Controller

This block is the serial test port of a device. A sixteen-state controller advances on every rising edge of the test clock. The level of the mode-select input at that edge picks which of the two successors of the current state comes next. Two branches of the state graph each give a capture, shift, pause and update sequence. One branch works on the instruction register. The other works on whichever data register the current instruction selects.

The block contains a one-bit bypass register and an optional identification register. The boundary scan chain stays outside the block. For that chain the block drives capture, shift and update strobes, decodes two mode selects, and takes the chain's serial output back in to route it to the port output. Several devices can share the clock, reset and mode-select lines while their serial data lines form a chain, so each device only has to behave correctly between its own serial input and serial output.

The serial output is valid only while a shift state is active. Its enable output models a tri-state driver.

Top module: `tap_ctrl`

## Requirements
- R1: The state advances only at the rising test clock edge, and the mode-select level at that edge alone picks the successor on the standard graph. From test-logic-reset, a high level stays in reset and a low level goes to run-test/idle.
- R2: Five consecutive edges with mode-select high reach test-logic-reset from any state. The instruction then becomes the identification opcode in the same edge that enters reset, and not before it.
- R3: A synchronous active-high reset, sampled at the clock edge, forces test-logic-reset and the identification instruction. It wins over an update-IR in the same cycle.
- R4: The edge that leaves capture-IR loads the IR shift stage with binary 01 in bits [1:0] and zeros above. The stage is shifted out LSB first.
- R5: In shift-IR each edge moves the serial input into the MSB and presents the next bit on the output. The instruction changes only on the edge that leaves update-IR, and the old instruction stays in force while update-IR is active.
- R6: Opcode 0001, which is the reset default, selects a 32-bit identification register. That register captures the ID_VALUE parameter on leaving capture-DR and shifts it out LSB first.
- R7: Opcode 1111, and any opcode other than 0000, 0001 or 0010, selects the bypass register. Bypass captures 0, so the output in shift-DR is the serial input delayed by one shift.
- R8: Opcode 0000 asserts the external-test mode select, and opcode 0010 asserts the sample mode select. With either opcode active, the chain capture, shift and update strobes are high exactly while the state is capture-DR, shift-DR and update-DR. In shift-DR the serial output then follows the chain's serial input.
- R9: The output enable is high only in shift-IR and shift-DR, and the serial output is 0 whenever the enable is low.
- R10: Pause-DR keeps the contents of the shift stage unchanged. Returning through exit2-DR to shift-DR continues with the next unread bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; all state changes on its rising edge |
| test_rst | input | 1 | Synchronous active-high reset of the controller |
| tms | input | 1 | Mode select steering the state graph |
| tdi | input | 1 | Serial test data in |
| tdo | output | 1 | Serial test data out, 0 when not enabled |
| tdo_oe | output | 1 | Drive enable for the serial output |
| chain_tdo | input | 1 | Serial output of the external boundary chain |
| chain_capture | output | 1 | Boundary chain capture strobe |
| chain_shift | output | 1 | Boundary chain shift strobe |
| chain_update | output | 1 | Boundary chain update strobe |
| mode_extest | output | 1 | External-test instruction active |
| mode_sample | output | 1 | Sample instruction active |

## Verification
Two of this block's functions can fall on the same edge: the instruction update that happens on leaving update-IR, and a reset request. The bench provokes the collision by walking the controller into update-IR with a new external-test opcode already shifted in, and then raising the reset for exactly that edge. The result is judged at the ports. The external-test select must stay low. A following data scan must then return the identification value, which shows that the reset default won over the pending instruction.

// File: rtl/tap_pkg.sv
package tap_pkg;
  typedef enum logic [3:0] {
    ST_RESET, ST_IDLE,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_t;
endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import tap_pkg::*;
(
  input  logic       tck,
  input  logic       rst,
  input  logic       tms,
  output tap_state_t state_q,
  output tap_state_t state_d
);
  always_comb begin
    case (state_q)
      ST_RESET:  state_d = tms ? ST_RESET  : ST_IDLE;
      ST_IDLE:   state_d = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_DR: state_d = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: state_d = tms ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  state_d = tms ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: state_d = tms ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: state_d = tms ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: state_d = tms ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: state_d = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_IR: state_d = tms ? ST_RESET  : ST_CAP_IR;
      ST_CAP_IR: state_d = tms ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  state_d = tms ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: state_d = tms ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: state_d = tms ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: state_d = tms ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: state_d = tms ? ST_SEL_DR : ST_IDLE;
      default:   state_d = ST_RESET;
    endcase
  end

  always_ff @(posedge tck) begin
    if (rst) state_q <= ST_RESET;
    else     state_q <= state_d;
  end
endmodule

// File: rtl/tap_ir.sv
module tap_ir
  import tap_pkg::*;
#(
  parameter int              IR_W     = 4,
  parameter logic [IR_W-1:0] RESET_OP = 1
)(
  input  logic            tck,
  input  logic            rst,
  input  tap_state_t      state_q,
  input  tap_state_t      state_d,
  input  logic            tdi,
  output logic [IR_W-1:0] ir_q,
  output logic            sr_lsb
);
  localparam logic [IR_W-1:0] CAPTURE_PAT = {{(IR_W-2){1'b0}}, 2'b01};

  logic [IR_W-1:0] sr_q;

  always_ff @(posedge tck) begin
    if (rst || state_d == ST_RESET) begin
      ir_q <= RESET_OP;
      sr_q <= CAPTURE_PAT;
    end else begin
      case (state_q)
        ST_CAP_IR: sr_q <= CAPTURE_PAT;
        ST_SH_IR:  sr_q <= {tdi, sr_q[IR_W-1:1]};
        ST_UPD_IR: ir_q <= sr_q;
        default:   ;
      endcase
    end
  end

  assign sr_lsb = sr_q[0];
endmodule

// File: rtl/tap_dregs.sv
module tap_dregs
  import tap_pkg::*;
#(
  parameter bit              HAS_ID   = 1'b1,
  parameter int              ID_W     = 32,
  parameter logic [ID_W-1:0] ID_VALUE = 32'h1A5C_3E01
)(
  input  logic       tck,
  input  tap_state_t state_q,
  input  logic       tdi,
  input  logic       sel_id,
  input  logic       sel_byp,
  output logic       id_lsb,
  output logic       byp_q
);
  always_ff @(posedge tck) begin
    if (sel_byp) begin
      if (state_q == ST_CAP_DR)     byp_q <= 1'b0;
      else if (state_q == ST_SH_DR) byp_q <= tdi;
    end
  end

  generate
    if (HAS_ID) begin : g_id
      logic [ID_W-1:0] id_sr;
      always_ff @(posedge tck) begin
        if (sel_id) begin
          if (state_q == ST_CAP_DR)     id_sr <= ID_VALUE;
          else if (state_q == ST_SH_DR) id_sr <= {tdi, id_sr[ID_W-1:1]};
        end
      end
      assign id_lsb = id_sr[0];
    end else begin : g_no_id
      assign id_lsb = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/tap_ctrl.sv
module tap_ctrl
  import tap_pkg::*;
#(
  parameter int              IR_W      = 4,
  parameter bit              HAS_ID    = 1'b1,
  parameter int              ID_W      = 32,
  parameter logic [ID_W-1:0] ID_VALUE  = 32'h1A5C_3E01,
  parameter logic [IR_W-1:0] OP_EXTEST = 0,
  parameter logic [IR_W-1:0] OP_IDCODE = 1,
  parameter logic [IR_W-1:0] OP_SAMPLE = 2
)(
  input  logic tck,
  input  logic test_rst,
  input  logic tms,
  input  logic tdi,
  output logic tdo,
  output logic tdo_oe,
  input  logic chain_tdo,
  output logic chain_capture,
  output logic chain_shift,
  output logic chain_update,
  output logic mode_extest,
  output logic mode_sample
);
  localparam logic [IR_W-1:0] OP_BYPASS = {IR_W{1'b1}};
  localparam logic [IR_W-1:0] OP_RESET  = HAS_ID ? OP_IDCODE : OP_BYPASS;

  tap_state_t      state_q, state_d;
  logic [IR_W-1:0] ir_q;
  logic            ir_lsb, id_lsb, byp_q;
  logic            sel_id, sel_chain, sel_byp;

  tap_fsm u_fsm (
    .tck     (tck),
    .rst     (test_rst),
    .tms     (tms),
    .state_q (state_q),
    .state_d (state_d)
  );

  tap_ir #(.IR_W(IR_W), .RESET_OP(OP_RESET)) u_ir (
    .tck     (tck),
    .rst     (test_rst),
    .state_q (state_q),
    .state_d (state_d),
    .tdi     (tdi),
    .ir_q    (ir_q),
    .sr_lsb  (ir_lsb)
  );

  assign mode_extest = (ir_q == OP_EXTEST);
  assign mode_sample = (ir_q == OP_SAMPLE);
  assign sel_id      = HAS_ID && (ir_q == OP_IDCODE);
  assign sel_chain   = mode_extest || mode_sample;
  assign sel_byp     = !sel_id && !sel_chain;

  tap_dregs #(.HAS_ID(HAS_ID), .ID_W(ID_W), .ID_VALUE(ID_VALUE)) u_dr (
    .tck     (tck),
    .state_q (state_q),
    .tdi     (tdi),
    .sel_id  (sel_id),
    .sel_byp (sel_byp),
    .id_lsb  (id_lsb),
    .byp_q   (byp_q)
  );

  assign chain_capture = sel_chain && (state_q == ST_CAP_DR);
  assign chain_shift   = sel_chain && (state_q == ST_SH_DR);
  assign chain_update  = sel_chain && (state_q == ST_UPD_DR);

  always_comb begin
    tdo_oe = 1'b0;
    tdo    = 1'b0;
    if (state_q == ST_SH_IR) begin
      tdo_oe = 1'b1;
      tdo    = ir_lsb;
    end else if (state_q == ST_SH_DR) begin
      tdo_oe = 1'b1;
      if (sel_id)         tdo = id_lsb;
      else if (sel_chain) tdo = chain_tdo;
      else                tdo = byp_q;
    end
  end
endmodule

// File: rtl/tap_ctrl_chk.sv
module tap_ctrl_chk
  import tap_pkg::*;
#(
  parameter int              IR_W     = 4,
  parameter logic [IR_W-1:0] OP_RESET = 1
)(
  input logic            tck,
  input logic            test_rst,
  input logic            tms,
  input tap_state_t      state_q,
  input tap_state_t      state_d,
  input logic [IR_W-1:0] ir_q,
  input logic            chain_capture,
  input logic            chain_shift,
  input logic            chain_update,
  input logic            tdo_oe
);
  localparam int HIGH_RUN = 5;
  logic [2:0] ones_cnt;

  always_ff @(posedge tck) begin
    if (test_rst)                   ones_cnt <= '0;
    else if (!tms)                  ones_cnt <= '0;
    else if (ones_cnt != HIGH_RUN)  ones_cnt <= ones_cnt + 3'd1;
  end

  AST_RESET_HOLD: assert property (@(posedge tck) disable iff (test_rst)
    (state_q == ST_RESET && tms) |=> state_q == ST_RESET); // R1
  AST_FIVE_HIGH: assert property (@(posedge tck) disable iff (test_rst)
    (ones_cnt == HIGH_RUN) |-> state_q == ST_RESET); // R2
  AST_SYNC_RESET_STATE: assert property (@(posedge tck)
    test_rst |=> state_q == ST_RESET); // R3
  AST_SYNC_RESET_IR: assert property (@(posedge tck)
    test_rst |=> ir_q == OP_RESET); // R3
  AST_IR_CHANGE_POINT: assert property (@(posedge tck) disable iff (test_rst)
    !$stable(ir_q) |-> ($past(test_rst) || $past(state_q) == ST_UPD_IR
                        || $past(state_d) == ST_RESET)); // R5
  AST_STROBES_EXCLUSIVE: assert property (@(posedge tck) disable iff (test_rst)
    $onehot0({chain_capture, chain_shift, chain_update})); // R8
  AST_CAPTURE_THEN_SHIFT: assert property (@(posedge tck) disable iff (test_rst)
    (chain_capture && !tms) |=> chain_shift); // R8
  AST_OE_STAYS_IN_SHIFT: assert property (@(posedge tck) disable iff (test_rst)
    (tdo_oe && !tms) |=> tdo_oe); // R9
endmodule

bind tap_ctrl tap_ctrl_chk #(.IR_W(IR_W), .OP_RESET(OP_RESET)) u_chk (
  .tck           (tck),
  .test_rst      (test_rst),
  .tms           (tms),
  .state_q       (state_q),
  .state_d       (state_d),
  .ir_q          (ir_q),
  .chain_capture (chain_capture),
  .chain_shift   (chain_shift),
  .chain_update  (chain_update),
  .tdo_oe        (tdo_oe)
);

// File: tb/sim_tap_ctrl.sv
`timescale 1ns/1ps
module sim_tap_ctrl;
  localparam logic [31:0] IDV = 32'h1A5C_3E01;

  logic tck = 1'b0;
  logic test_rst = 1'b1;
  logic tms = 1'b1, tdi = 1'b0, chain_tdo = 1'b0;
  logic tdo, tdo_oe, chain_capture, chain_shift, chain_update, mode_extest, mode_sample;
  int checks = 0, failures = 0;

  always #10 tck = ~tck;

  tap_ctrl #(.ID_VALUE(IDV)) u0 (
    .tck(tck), .test_rst(test_rst), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_oe(tdo_oe),
    .chain_tdo(chain_tdo), .chain_capture(chain_capture), .chain_shift(chain_shift),
    .chain_update(chain_update), .mode_extest(mode_extest), .mode_sample(mode_sample)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic m, input logic d);
    @(negedge tck);
    tms = m;
    tdi = d;
    @(posedge tck);
    #2;
  endtask

  task automatic dr_scan(input int n, input logic [63:0] din, output logic [63:0] dout);
    dout = '0;
    step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < n; i++) begin
      dout[i] = tdo;
      step(i == n - 1, din[i]);
    end
    step(1, 0); step(0, 0);
  endtask

  task automatic ir_scan(input logic [3:0] din, output logic [3:0] dout);
    dout = '0;
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 4; i++) begin
      dout[i] = tdo;
      step(i == 3, din[i]);
    end
    step(1, 0); step(0, 0);
  endtask

  task automatic t_reset;
    @(negedge tck); test_rst = 1'b1;
    repeat (2) @(posedge tck);
    #2; test_rst = 1'b0;
    chk("R9 oe after reset", tdo_oe, 0);
    chk("R9 tdo after reset", tdo, 0);
    chk("R3 no mode select after reset", {mode_extest, mode_sample}, 0);
    step(1, 0); step(1, 0);
    chk("R1 high tms holds reset", {tdo_oe, chain_capture}, 0);
    step(0, 0);
  endtask

  task automatic t_idcode;
    logic [63:0] o;
    dr_scan(32, 64'h0, o);
    chk("R1 R6 identification scan", o[31:0], IDV);
  endtask

  task automatic t_ir_capture_bypass;
    logic [3:0] o;
    logic [63:0] d;
    ir_scan(4'b1111, o);
    chk("R4 IR capture pattern", o, 4'b0001);
    dr_scan(8, 64'hB2, d);
    chk("R7 bypass one-bit delay", d[7:0], 8'h64);
  endtask

  task automatic t_extest;
    logic [3:0] o;
    ir_scan(4'b0000, o);
    chk("R8 extest select", {mode_extest, mode_sample}, 2'b10);
    step(1, 0);
    chk("R8 no strobe in select-DR", {chain_capture, chain_shift, chain_update}, 0);
    step(0, 0);
    chk("R8 capture strobe", {chain_capture, chain_shift, chain_update}, 3'b100);
    step(0, 0);
    chk("R8 shift strobe", {chain_capture, chain_shift, chain_update}, 3'b010);
    chain_tdo = 1'b1; #1;
    chk("R8 chain routed high", {tdo_oe, tdo}, 2'b11);
    chain_tdo = 1'b0; #1;
    chk("R8 chain routed low", {tdo_oe, tdo}, 2'b10);
    step(1, 0);
    chk("R9 exit1 no drive", {tdo_oe, chain_shift}, 0);
    step(1, 0);
    chk("R8 update strobe", {chain_capture, chain_shift, chain_update}, 3'b001);
    step(0, 0);
  endtask

  task automatic t_sample_unknown;
    logic [3:0] o;
    logic [63:0] d;
    ir_scan(4'b0010, o);
    chk("R8 sample select", {mode_extest, mode_sample}, 2'b01);
    ir_scan(4'b0101, o);
    chk("R7 unassigned opcode no select", {mode_extest, mode_sample}, 0);
    dr_scan(4, 64'hD, d);
    chk("R7 unassigned opcode acts as bypass", d[3:0], 4'b1010);
  endtask

  task automatic t_five_high;
    logic [3:0] o;
    logic [63:0] d;
    ir_scan(4'b0000, o);
    step(1, 0); step(0, 0); step(0, 0);
    step(1, 0); step(1, 0); step(1, 0); step(1, 0);
    chk("R2 instruction kept before fifth edge", mode_extest, 1);
    step(1, 0);
    chk("R2 fifth edge restores identification", mode_extest, 0);
    step(0, 0);
    dr_scan(32, 64'h0, d);
    chk("R2 identification after five high", d[31:0], IDV);
  endtask

  task automatic t_pause;
    logic [7:0] a, b;
    step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 8; i++) begin a[i] = tdo; step(i == 7, 0); end
    step(0, 0);
    chk("R9 pause not driven", tdo_oe, 0);
    step(0, 0); step(1, 0); step(0, 0);
    for (int i = 0; i < 8; i++) begin b[i] = tdo; step(i == 7, 0); end
    step(1, 0); step(0, 0);
    chk("R10 first part", a, IDV[7:0]);
    chk("R10 continue after pause", b, IDV[15:8]);
  endtask

  task automatic t_reset_vs_update;
    logic [63:0] d;
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 4; i++) step(i == 3, 0);
    step(1, 0);
    chk("R5 old instruction in update-IR", mode_extest, 0);
    test_rst = 1'b1;
    step(0, 0);
    test_rst = 1'b0;
    chk("R3 reset beats update", {mode_extest, tdo_oe}, 0);
    step(0, 0);
    dr_scan(32, 64'h0, d);
    chk("R3 identification after collision", d[31:0], IDV);
  endtask

  initial begin
    t_reset();
    t_idcode();
    t_ir_capture_bypass();
    t_extest();
    t_sample_unknown();
    t_five_high();
    t_pause();
    t_reset_vs_update();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge tck);
    checks++;
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule